// File: doc/BRIEF.md
# Code-Loader Stream Control Register File

This block is the register front end of a single-stream DMA that moves code from host memory to a device. Software reaches it over a simple 32-bit write/read register bus. It holds the stream control word, the stream status flags, the descriptor-list base address, the cyclic buffer length, the index of the last valid descriptor and a software position limit with its own enable. It also holds a top-level interrupt enable and status pair that gates the single interrupt line.

Run and stream-reset are handshakes. A write to the control word only requests a state change. The matching readback bit, and the level handed to the data engine, change only after a parameterised acknowledge delay. Software therefore polls the readback bit to learn that the engine has followed. The descriptor walker receives the configuration fields, the run and reset levels and a one-cycle start strobe. It returns completion and error event pulses, which set the status flags.

Top module: `ldr_stream_csr`

## Requirements
- R1: After reset, every mapped register reads 0, and `run_o`, `srst_o`, `start_o` and `irq_o` are 0.
- R2: The descriptor base low word (offset 0x90) keeps only bits 31:7. Bits 6:0 read 0 and are 0 on `cfg_base_o`. The high word (0x94) keeps all 32 bits and drives `cfg_base_o[63:32]`.
- R3: Control bit 0 requests stream reset. It reads back 1, and `srst_o` rises, exactly ACK_DLY clock edges after the write that set it. After a write clears the bit, it reads back 0 ACK_DLY edges later.
- R4: Control bit 1 requests run. It reads back 1 and `run_o` rises ACK_DLY edges after the write, and `start_o` pulses for exactly that one cycle. A clearing write makes the bit read 0 ACK_DLY edges later.
- R5: The stream tag is held in control bits 23:20. It reads back there and drives `cfg_tag_o`.
- R6: Status (0x84) bit 2 is the completion flag and bit 3 is the error flag. They are set by `eng_done_i` and `eng_err_i` and cleared by writing 1 to the bit. Writing 0 has no effect.
- R7: The stream interrupt condition is (completion flag AND control bit 2) OR (error flag AND control bit 3). It reads as bit 0 of the top status word (0x00). `irq_o` is that condition gated by bit 0 of the top enable word (0x04).
- R8: Position enable is bit 0 at offset 0x24 and the position value is at 0x28. Both read back and drive `pos_en_o` and `pos_o`.
- R9: The buffer length (0x88, 32 bits) and the last-valid-index (0x8C, low LVI_W bits) read back and drive `cfg_len_o` and `cfg_lvi_o`.
- R10: While the acknowledged reset state is 1, both status flags are forced to 0 and engine events are ignored.
- R11: Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| eng_done_i | input | 1 | Completion event from the engine |
| eng_err_i | input | 1 | Error event from the engine |
| cfg_base_o | output | 64 | Descriptor-list base address |
| cfg_len_o | output | 32 | Cyclic buffer length |
| cfg_lvi_o | output | 8 | Last valid descriptor index |
| cfg_tag_o | output | 4 | Stream tag |
| pos_en_o | output | 1 | Position bounding enable |
| pos_o | output | 32 | Software position limit |
| run_o | output | 1 | Acknowledged run level |
| srst_o | output | 1 | Acknowledged stream reset level |
| start_o | output | 1 | One-cycle strobe when run is acknowledged |
| irq_o | output | 1 | Interrupt line |

## Verification
The assertions check on every cycle that an acknowledge bit changes only towards the value last requested and holds steady while request and acknowledge agree. They also check that an engine event sets its flag, that a write-one clear removes it, that the acknowledged reset state empties the status, and that a pending interrupt condition always has a flag behind it. Only the bench scenarios can show the exact acknowledge latency, the single-cycle start strobe, the field positions and masking of the registers, the gating by the top-level enable, and that writing 0 to a status bit leaves it set.

// File: rtl/ldr_csr_pkg.sv
package ldr_csr_pkg;
  localparam logic [7:0] OFS_TOP_STS  = 8'h00;
  localparam logic [7:0] OFS_TOP_EN   = 8'h04;
  localparam logic [7:0] OFS_POS_EN   = 8'h24;
  localparam logic [7:0] OFS_POS_VAL  = 8'h28;
  localparam logic [7:0] OFS_CTL      = 8'h80;
  localparam logic [7:0] OFS_STS      = 8'h84;
  localparam logic [7:0] OFS_LEN      = 8'h88;
  localparam logic [7:0] OFS_LVI      = 8'h8C;
  localparam logic [7:0] OFS_BASE_LO  = 8'h90;
  localparam logic [7:0] OFS_BASE_HI  = 8'h94;

  localparam int CTL_SRST  = 0;
  localparam int CTL_RUN   = 1;
  localparam int BIT_DONE  = 2;
  localparam int BIT_ERR   = 3;
  localparam int TAG_LSB   = 20;
  localparam int TAG_W     = 4;

  typedef enum logic [0:0] {HS_SRST = 1'b0, HS_RUN = 1'b1} hs_sel_e;
endpackage

// File: rtl/ldr_hs.sv
module ldr_hs #(
  parameter int DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic ack_o
);
  localparam int CW = $clog2(DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(DLY - 1);

  logic          ack_q, ack_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    ack_d = ack_q;
    cnt_d = '0;
    if (req_i != ack_q) begin
      if (cnt_q == LAST) ack_d = req_i;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      ack_q <= ack_d;
      cnt_q <= cnt_d;
    end
  end

  assign ack_o = ack_q;

  // R3
  ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q != $past(ack_q)) |-> (ack_q == $past(req_i)));
  // R4
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == ack_q) |=> $stable(ack_q));
endmodule

// File: rtl/ldr_sts.sv
module ldr_sts (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_done_i,
  input  logic       evt_err_i,
  input  logic       hold_clr_i,
  input  logic       clr_we_i,
  input  logic [1:0] clr_mask_i,
  input  logic [1:0] ie_i,
  output logic       done_o,
  output logic       err_o,
  output logic       pend_o
);
  logic done_q, done_d, err_q, err_d;

  always_comb begin
    if (hold_clr_i) begin
      done_d = 1'b0;
      err_d  = 1'b0;
    end else begin
      done_d = evt_done_i | (done_q & ~(clr_we_i & clr_mask_i[0]));
      err_d  = evt_err_i  | (err_q  & ~(clr_we_i & clr_mask_i[1]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;
  assign pend_o = (done_q & ie_i[0]) | (err_q & ie_i[1]);

  // R6
  sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_err_i && !hold_clr_i) |=> err_q);
  // R6
  sts_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && clr_mask_i[0] && !evt_done_i) |=> !done_q);
  // R10
  rst_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_clr_i |=> (!done_q && !err_q));
  // R7
  pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o |-> (done_q || err_q));
endmodule

// File: rtl/ldr_stream_csr.sv
module ldr_stream_csr
  import ldr_csr_pkg::*;
#(
  parameter int ACK_DLY    = 4,
  parameter int LVI_W      = 8,
  parameter int ALIGN_BITS = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr_i,
  input  logic [7:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  input  logic        eng_done_i,
  input  logic        eng_err_i,
  output logic [63:0] cfg_base_o,
  output logic [31:0] cfg_len_o,
  output logic [LVI_W-1:0] cfg_lvi_o,
  output logic [3:0]  cfg_tag_o,
  output logic        pos_en_o,
  output logic [31:0] pos_o,
  output logic        run_o,
  output logic        srst_o,
  output logic        start_o,
  output logic        irq_o
);
  localparam int BASE_W = 32 - ALIGN_BITS;

  logic [1:0]        hs_req_q, hs_ack;
  logic [1:0]        ie_q;
  logic [TAG_W-1:0]  tag_q;
  logic              top_en_q, pos_en_q, run_seen_q;
  logic [BASE_W-1:0] base_lo_q;
  logic [31:0]       base_hi_q, len_q, pos_q;
  logic [LVI_W-1:0]  lvi_q;
  logic              sts_done, sts_err, pend;

  logic we_ctl, we_sts, we_top, we_pen, we_pos, we_len, we_lvi, we_blo, we_bhi;

  always_comb begin
    we_ctl = bus_wr_i && (bus_addr_i == OFS_CTL);
    we_sts = bus_wr_i && (bus_addr_i == OFS_STS);
    we_top = bus_wr_i && (bus_addr_i == OFS_TOP_EN);
    we_pen = bus_wr_i && (bus_addr_i == OFS_POS_EN);
    we_pos = bus_wr_i && (bus_addr_i == OFS_POS_VAL);
    we_len = bus_wr_i && (bus_addr_i == OFS_LEN);
    we_lvi = bus_wr_i && (bus_addr_i == OFS_LVI);
    we_blo = bus_wr_i && (bus_addr_i == OFS_BASE_LO);
    we_bhi = bus_wr_i && (bus_addr_i == OFS_BASE_HI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_req_q   <= '0;
      ie_q       <= '0;
      tag_q      <= '0;
      top_en_q   <= 1'b0;
      pos_en_q   <= 1'b0;
      pos_q      <= '0;
      len_q      <= '0;
      lvi_q      <= '0;
      base_lo_q  <= '0;
      base_hi_q  <= '0;
      run_seen_q <= 1'b0;
    end else begin
      run_seen_q <= hs_ack[HS_RUN];
      if (we_ctl) begin
        hs_req_q[HS_SRST] <= bus_wdata_i[CTL_SRST];
        hs_req_q[HS_RUN]  <= bus_wdata_i[CTL_RUN];
        ie_q              <= {bus_wdata_i[BIT_ERR], bus_wdata_i[BIT_DONE]};
        tag_q             <= bus_wdata_i[TAG_LSB +: TAG_W];
      end
      if (we_top) top_en_q  <= bus_wdata_i[0];
      if (we_pen) pos_en_q  <= bus_wdata_i[0];
      if (we_pos) pos_q     <= bus_wdata_i;
      if (we_len) len_q     <= bus_wdata_i;
      if (we_lvi) lvi_q     <= bus_wdata_i[LVI_W-1:0];
      if (we_blo) base_lo_q <= bus_wdata_i[31:ALIGN_BITS];
      if (we_bhi) base_hi_q <= bus_wdata_i;
    end
  end

  for (genvar gi = 0; gi < 2; gi++) begin : g_hs
    ldr_hs #(.DLY(ACK_DLY)) u_hs (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (hs_req_q[gi]),
      .ack_o (hs_ack[gi])
    );
  end

  ldr_sts u_sts (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_done_i (eng_done_i),
    .evt_err_i  (eng_err_i),
    .hold_clr_i (hs_ack[HS_SRST]),
    .clr_we_i   (we_sts),
    .clr_mask_i ({bus_wdata_i[BIT_ERR], bus_wdata_i[BIT_DONE]}),
    .ie_i       (ie_q),
    .done_o     (sts_done),
    .err_o      (sts_err),
    .pend_o     (pend)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      OFS_TOP_STS: bus_rdata_o[0] = pend;
      OFS_TOP_EN:  bus_rdata_o[0] = top_en_q;
      OFS_POS_EN:  bus_rdata_o[0] = pos_en_q;
      OFS_POS_VAL: bus_rdata_o    = pos_q;
      OFS_CTL: begin
        bus_rdata_o[CTL_SRST]              = hs_ack[HS_SRST];
        bus_rdata_o[CTL_RUN]               = hs_ack[HS_RUN];
        bus_rdata_o[BIT_DONE]              = ie_q[0];
        bus_rdata_o[BIT_ERR]               = ie_q[1];
        bus_rdata_o[TAG_LSB +: TAG_W]      = tag_q;
      end
      OFS_STS: begin
        bus_rdata_o[BIT_DONE] = sts_done;
        bus_rdata_o[BIT_ERR]  = sts_err;
      end
      OFS_LEN:     bus_rdata_o            = len_q;
      OFS_LVI:     bus_rdata_o[LVI_W-1:0] = lvi_q;
      OFS_BASE_LO: bus_rdata_o[31:ALIGN_BITS] = base_lo_q;
      OFS_BASE_HI: bus_rdata_o            = base_hi_q;
      default:     bus_rdata_o            = '0;
    endcase
  end

  assign cfg_base_o = {base_hi_q, base_lo_q, {ALIGN_BITS{1'b0}}};
  assign cfg_len_o  = len_q;
  assign cfg_lvi_o  = lvi_q;
  assign cfg_tag_o  = tag_q;
  assign pos_en_o   = pos_en_q;
  assign pos_o      = pos_q;
  assign run_o      = hs_ack[HS_RUN];
  assign srst_o     = hs_ack[HS_SRST];
  assign start_o    = hs_ack[HS_RUN] & ~run_seen_q;
  assign irq_o      = pend & top_en_q;

  // R4
  start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
endmodule

// File: tb/ldr_stream_csr_bench.sv
`timescale 1ns/1ps
module ldr_stream_csr_bench;
  localparam int DLY = 4;

  logic        clk, rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        eng_done, eng_err;
  logic [63:0] cfg_base;
  logic [31:0] cfg_len, pos;
  logic [7:0]  cfg_lvi;
  logic [3:0]  cfg_tag;
  logic        pos_en, run, srst, start, irq;

  int total = 0;
  int bad   = 0;

  ldr_stream_csr #(.ACK_DLY(DLY)) u_ldr_stream_csr (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .eng_done_i(eng_done), .eng_err_i(eng_err),
    .cfg_base_o(cfg_base), .cfg_len_o(cfg_len), .cfg_lvi_o(cfg_lvi),
    .cfg_tag_o(cfg_tag), .pos_en_o(pos_en), .pos_o(pos),
    .run_o(run), .srst_o(srst), .start_o(start), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic dn, input logic er);
    @(negedge clk);
    eng_done = dn; eng_err = er;
    @(negedge clk);
    eng_done = 1'b0; eng_err = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h80, d); chk("R1 ctl", d, 0);
    rd(8'h84, d); chk("R1 sts", d, 0);
    rd(8'h00, d); chk("R1 topsts", d, 0);
    rd(8'h90, d); chk("R1 base", d, 0);
    chk("R1 outs", {run, srst, start, irq}, 0);
  endtask

  task automatic t_base;
    logic [31:0] d;
    wr(8'h90, 32'hFFFF_FFFF);
    wr(8'h94, 32'h1234_5678);
    rd(8'h90, d); chk("R2 lo", d, 32'hFFFF_FF80);
    rd(8'h94, d); chk("R2 hi", d, 32'h1234_5678);
    chk("R2 out", cfg_base, 64'h1234_5678_FFFF_FF80);
  endtask

  task automatic t_tag;
    logic [31:0] d;
    wr(8'h80, 32'h00A0_000C);
    rd(8'h80, d); chk("R5 ctl", d, 32'h00A0_000C);
    chk("R5 tag", cfg_tag, 4'hA);
    wr(8'h80, 0);
  endtask

  task automatic t_srst;
    logic [31:0] d;
    wr(8'h80, 32'h1);
    wait_edges(DLY - 1);
    rd(8'h80, d); chk("R3 early", d[0], 0);
    chk("R3 srst early", srst, 0);
    wait_edges(1);
    rd(8'h80, d); chk("R3 ack", d[0], 1);
    chk("R3 srst", srst, 1);
    wr(8'h80, 0);
    wait_edges(DLY - 1);
    rd(8'h80, d); chk("R3 held", d[0], 1);
    wait_edges(1);
    rd(8'h80, d); chk("R3 release", d[0], 0);
  endtask

  task automatic t_run;
    logic [31:0] d;
    wr(8'h80, 32'h2);
    wait_edges(DLY - 1);
    rd(8'h80, d); chk("R4 early", d[1], 0);
    chk("R4 start early", start, 0);
    wait_edges(1);
    rd(8'h80, d); chk("R4 ack", d[1], 1);
    chk("R4 run", run, 1);
    chk("R4 start", start, 1);
    wait_edges(1);
    chk("R4 start one cycle", start, 0);
    wr(8'h80, 0);
    wait_edges(DLY - 1);
    rd(8'h80, d); chk("R4 still", d[1], 1);
    wait_edges(1);
    rd(8'h80, d); chk("R4 stop", d[1], 0);
  endtask

  task automatic t_sts;
    logic [31:0] d;
    pulse(1, 0);
    rd(8'h84, d); chk("R6 done set", d, 32'h4);
    wr(8'h84, 32'h8);
    rd(8'h84, d); chk("R6 other bit", d, 32'h4);
    wr(8'h84, 32'h0);
    rd(8'h84, d); chk("R6 write zero", d, 32'h4);
    wr(8'h84, 32'h4);
    rd(8'h84, d); chk("R6 done clr", d, 0);
    pulse(0, 1);
    rd(8'h84, d); chk("R6 err set", d, 32'h8);
    wr(8'h84, 32'hC);
    rd(8'h84, d); chk("R6 err clr", d, 0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(8'h80, 32'h4);
    pulse(0, 1);
    rd(8'h00, d); chk("R7 err masked", d, 0);
    pulse(1, 0);
    rd(8'h00, d); chk("R7 topsts", d, 1);
    chk("R7 gated", irq, 0);
    wr(8'h04, 1);
    chk("R7 irq", irq, 1);
    wr(8'h80, 32'h0);
    chk("R7 ie off", irq, 0);
    wr(8'h80, 32'h8);
    chk("R7 err ie", irq, 1);
    wr(8'h84, 32'hC);
    chk("R7 cleared", irq, 0);
    wr(8'h80, 0);
    wr(8'h04, 0);
  endtask

  task automatic t_pos;
    logic [31:0] d;
    wr(8'h24, 1);
    wr(8'h28, 32'h0000_1234);
    rd(8'h24, d); chk("R8 en", d, 1);
    rd(8'h28, d); chk("R8 val", d, 32'h1234);
    chk("R8 outs", {pos_en, pos}, {1'b1, 32'h1234});
  endtask

  task automatic t_len;
    logic [31:0] d;
    wr(8'h88, 32'h0001_0000);
    wr(8'h8C, 32'h1FF);
    rd(8'h88, d); chk("R9 len", d, 32'h0001_0000);
    rd(8'h8C, d); chk("R9 lvi", d, 32'hFF);
    chk("R9 outs", {cfg_len, cfg_lvi}, {32'h0001_0000, 8'hFF});
  endtask

  task automatic t_hold;
    logic [31:0] d;
    pulse(1, 1);
    wr(8'h80, 32'h1);
    wait_edges(DLY + 1);
    rd(8'h84, d); chk("R10 flush", d, 0);
    pulse(1, 1);
    rd(8'h84, d); chk("R10 ignore", d, 0);
    wr(8'h80, 0);
    wait_edges(DLY + 1);
  endtask

  task automatic t_unmap;
    logic [31:0] d;
    rd(8'h40, d); chk("R11 hole", d, 0);
    rd(8'hFC, d); chk("R11 top", d, 0);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    eng_done = 1'b0; eng_err = 1'b0;
    wait_edges(3);
    rst_n = 1'b1;
    wait_edges(1);
    t_reset;
    t_base;
    t_tag;
    t_srst;
    t_run;
    t_sts;
    t_irq;
    t_pos;
    t_len;
    t_hold;
    t_unmap;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule